// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer

This block is a 15-bit up-counter that advances once per CPU cycle and raises an interrupt request when it reaches its terminal value. The counter and its enable flag share one 16-bit register, which the CPU reaches as two byte-wide windows on a plain address, data and write-strobe bus. The enable is the top bit of the high byte, and the count value fills the remaining fifteen bits.

Software loads a start value and sets the enable. The counter then climbs until all fifteen count bits are ones. At that point it raises a level-sensitive interrupt and stops there. Any write to either byte window acknowledges the interrupt, so reloading the counter for the next interval also clears the request. Reads return the live count, and reads have no side effects.

Top module: `cyc_irq_timer`

## Requirements
- R1: A synchronous reset clears the enable, the count and the interrupt. After reset, both windows read 0x00 and `irq` is low.
- R2: A write to 0x5000–0x57FF loads count bits 7:0 from the data byte. A write to 0x5800–0x5FFF loads the enable from data bit 7 and count bits 14:8 from data bits 6:0. The new value is visible after the write's clock edge.
- R3: While the enable is set and the count is below 0x7FFF, the count rises by one on every clock. The carry ripples from the low byte into the high byte.
- R4: While the enable is clear, the count holds its value.
- R5: When an increment makes the count 0x7FFF, `irq` goes high. The count then stays at 0x7FFF, with no wrap, for as long as no write occurs.
- R6: Writing 0x7FFF directly into the counter does not raise `irq`, even with the enable set.
- R7: A write to either counter window clears `irq` at that write's clock edge.
- R8: A read of the low window returns count bits 7:0. A read of the high window returns the enable in bit 7 and count bits 14:8 in bits 6:0. Any other address reads 0x00, and writes to other addresses change nothing.
- R9: When a write and an increment fall on the same clock, the write wins. The byte that is not written keeps its value from before the edge, with no increment.
- R10: Once raised, `irq` stays high until a counter write or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data, combinational from the live counter |
| irq | output | 1 | Interrupt request, active high, level |

## Verification
A wrong count shows up on the very next read of either window, because reads mux the live register with no delay. A mistaken enable or a wrong saturation rule shows up as a low byte that fails to follow the number of elapsed clocks. Errors in the interrupt flag show up on `irq` one edge after the event that should set or clear it. This covers a missing acknowledge, a raise on a loaded terminal value, and a drop without a write. A write that is lost against a simultaneous increment shows up as an off-by-one in the byte that was not written.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;

    // Which counter window, if any, the current bus address selects.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_LO   = 2'd1,
        WIN_HI   = 2'd2
    } win_e;

endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode
    import cyc_irq_pkg::*;
#(
    parameter int unsigned  ADDR_W   = 16,
    parameter logic [15:0]  WIN_MASK = 16'hF800,
    parameter logic [15:0]  LO_BASE  = 16'h5000,
    parameter logic [15:0]  HI_BASE  = 16'h5800
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output win_e              win,
    output logic              wr_lo,
    output logic              wr_hi
);

    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(WIN_MASK);
    localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(LO_BASE);
    localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(HI_BASE);

    logic hit_lo;
    logic hit_hi;

    always_comb begin
        hit_lo = (addr & MASK_A) == LO_A;
        hit_hi = (addr & MASK_A) == HI_A;
        if (hit_lo) begin
            win = WIN_LO;
        end else if (hit_hi) begin
            win = WIN_HI;
        end else begin
            win = WIN_NONE;
        end
        wr_lo = we && hit_lo;
        wr_hi = we && hit_hi;
    end

endmodule

// File: rtl/cyc_irq_core.sv
module cyc_irq_core #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic              en_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              pend_q
);

    localparam int unsigned      HI_W = CNT_W - DATA_W;
    localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } tmr_state_t;

    tmr_state_t       tmr_d;
    tmr_state_t       tmr_q;
    logic [CNT_W-1:0] inc_d;

    always_comb begin
        tmr_d = tmr_q;
        inc_d = tmr_q.cnt + CNT_W'(1);
        if (wr_lo) begin
            // A bus write takes priority over counting (R9) and acknowledges.
            tmr_d.cnt[DATA_W-1:0] = wdata;
            tmr_d.pend            = 1'b0;
        end else if (wr_hi) begin
            tmr_d.en                   = wdata[DATA_W-1];
            tmr_d.cnt[CNT_W-1:DATA_W]  = wdata[HI_W-1:0];
            tmr_d.pend                 = 1'b0;
        end else if (tmr_q.en && (tmr_q.cnt != TERM)) begin
            tmr_d.cnt = inc_d;
            if (inc_d == TERM) begin
                tmr_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign en_q   = tmr_q.en;
    assign cnt_q  = tmr_q.cnt;
    assign pend_q = tmr_q.pend;

endmodule

// File: rtl/cyc_irq_rdmux.sv
module cyc_irq_rdmux
    import cyc_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 15
) (
    input  win_e              win,
    input  logic              en,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (win)
            WIN_LO:  rdata = cnt[DATA_W-1:0];
            WIN_HI:  rdata = {en, cnt[CNT_W-1:DATA_W]};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cyc_irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CNT_W    = 15,
    parameter logic [15:0] WIN_MASK = 16'hF800,
    parameter logic [15:0] LO_BASE  = 16'h5000,
    parameter logic [15:0] HI_BASE  = 16'h5800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    win_e             win;
    logic             wr_lo;
    logic             wr_hi;
    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;

    cyc_irq_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_MASK(WIN_MASK),
        .LO_BASE (LO_BASE),
        .HI_BASE (HI_BASE)
    ) u_decode (
        .addr (bus_addr),
        .we   (bus_we),
        .win  (win),
        .wr_lo(wr_lo),
        .wr_hi(wr_hi)
    );

    cyc_irq_core #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_core (
        .clk   (clk),
        .rst   (rst),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (bus_wdata),
        .en_q  (en_q),
        .cnt_q (cnt_q),
        .pend_q(pend_q)
    );

    cyc_irq_rdmux #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_rdmux (
        .win  (win),
        .en   (en_q),
        .cnt  (cnt_q),
        .rdata(bus_rdata)
    );

    assign irq = pend_q;

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_lo,
    input logic              wr_hi,
    input logic [DATA_W-1:0] wdata,
    input logic              en,
    input logic [CNT_W-1:0]  cnt,
    input logic              irq
);

    localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

    logic wr_any;
    assign wr_any = wr_lo || wr_hi;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (cnt == '0) && !en && !irq);

    assert_load_lo_R2: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> cnt[DATA_W-1:0] == $past(wdata));

    assert_load_hi_R2: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (en == $past(wdata[DATA_W-1])) &&
                  (cnt[CNT_W-1:DATA_W] == $past(wdata[CNT_W-DATA_W-1:0])));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (en && (cnt != TERM) && !wr_any) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_any) |=> $stable(cnt));

    assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt == TERM && !wr_any) |=> cnt == TERM);

    assert_irq_from_count_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cnt == TERM) && $past(en) && !$past(wr_any));

    assert_ack_R7: assert property (@(posedge clk) disable iff (rst)
        wr_any |=> !irq);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W]));

    assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_any) |=> irq);

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .wr_lo(wr_lo),
    .wr_hi(wr_hi),
    .wdata(bus_wdata),
    .en   (en_q),
    .cnt  (cnt_q),
    .irq  (irq)
);

// File: tb/sim_cyc_irq_timer.sv
module sim_cyc_irq_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;
    localparam int NVEC       = 23;

    // we, write address, write data, idle clocks, read address, expected read, expected irq, requirement
    typedef struct packed {
        logic        we;
        logic [15:0] waddr;
        logic [7:0]  wdata;
        logic [7:0]  idle;
        logic [15:0] raddr;
        logic [7:0]  exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        {1'b1, 16'h5000, 8'h10, 8'd0,  16'h5000, 8'h10, 1'b0, 4'd2},  // R2 low load, disabled
        {1'b1, 16'h5800, 8'h00, 8'd5,  16'h5000, 8'h10, 1'b0, 4'd4},  // R4 hold while disabled
        {1'b1, 16'h5800, 8'h80, 8'd0,  16'h5800, 8'h80, 1'b0, 4'd2},  // R2 enable via high byte
        {1'b0, 16'h0000, 8'h00, 8'd3,  16'h5000, 8'h13, 1'b0, 4'd3},  // R3 three steps
        {1'b1, 16'h5000, 8'hFD, 8'd0,  16'h5000, 8'hFD, 1'b0, 4'd9},  // R9 write beats increment
        {1'b1, 16'h5800, 8'hFF, 8'd0,  16'h5800, 8'hFF, 1'b0, 4'd2},  // R2 count 0x7FFD
        {1'b0, 16'h0000, 8'h00, 8'd1,  16'h5000, 8'hFE, 1'b0, 4'd3},  // R3
        {1'b0, 16'h0000, 8'h00, 8'd1,  16'h5000, 8'hFF, 1'b1, 4'd5},  // R5 terminal raises irq
        {1'b0, 16'h0000, 8'h00, 8'd10, 16'h5800, 8'hFF, 1'b1, 4'd5},  // R5 saturation, R10 level
        {1'b1, 16'h5000, 8'h00, 8'd0,  16'h5000, 8'h00, 1'b0, 4'd7},  // R7 ack by low write
        {1'b1, 16'h5800, 8'h7F, 8'd4,  16'h5000, 8'h00, 1'b0, 4'd9},  // R9 low byte not stepped
        {1'b1, 16'h4800, 8'h55, 8'd0,  16'h5000, 8'h00, 1'b0, 4'd8},  // R8 foreign write ignored
        {1'b0, 16'h0000, 8'h00, 8'd0,  16'h5800, 8'h7F, 1'b0, 4'd8},  // R8 high read
        {1'b0, 16'h0000, 8'h00, 8'd0,  16'h6000, 8'h00, 1'b0, 4'd8},  // R8 other address reads 0
        {1'b1, 16'h5000, 8'hFF, 8'd0,  16'h5000, 8'hFF, 1'b0, 4'd2},  // R2 count 0x7FFF disabled
        {1'b1, 16'h5800, 8'hFF, 8'd3,  16'h5000, 8'hFF, 1'b0, 4'd6},  // R6 loaded terminal no irq
        {1'b1, 16'h5000, 8'hFE, 8'd0,  16'h5000, 8'hFE, 1'b0, 4'd2},  // R2
        {1'b0, 16'h0000, 8'h00, 8'd1,  16'h5000, 8'hFF, 1'b1, 4'd5},  // R5
        {1'b1, 16'h5800, 8'h80, 8'd0,  16'h5800, 8'h80, 1'b0, 4'd7},  // R7 ack by high write
        {1'b0, 16'h0000, 8'h00, 8'd2,  16'h5000, 8'h01, 1'b0, 4'd3},  // R3 carry 0x00FF -> 0x0101
        {1'b0, 16'h0000, 8'h00, 8'd0,  16'h5800, 8'h81, 1'b0, 4'd3},  // R3 carry reached high byte
        {1'b1, 16'h57FF, 8'h20, 8'd0,  16'h5123, 8'h20, 1'b0, 4'd2},  // R2 window edge alias
        {1'b1, 16'h5FFF, 8'h05, 8'd2,  16'h5800, 8'h05, 1'b0, 4'd4}   // R4 disabled via high edge
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cyc_irq_timer u0 (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual=0x%02h expected=0x%02h", req, what, act, exp);
        end
    endtask

    task automatic check1(input logic act, input logic exp, input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Starts just after a falling edge; returns just after a falling edge.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = '0;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
        end
        #1;
    endtask

    task automatic peek(input logic [15:0] a);
        bus_addr = a;
        #1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        peek(16'h5000);
        check8(bus_rdata, 8'h00, 1, "low byte after reset");
        check1(irq, 1'b0, 1, "irq after reset");
        peek(16'h5800);
        check8(bus_rdata, 8'h00, 1, "high byte after reset");

        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].we) begin
                bus_write(VECS[v].waddr, VECS[v].wdata);
            end
            if (VECS[v].idle != 0) begin
                idle(int'(VECS[v].idle));
            end
            peek(VECS[v].raddr);
            check8(bus_rdata, VECS[v].exp_rd, int'(VECS[v].req), $sformatf("vector %0d read", v));
            check1(irq, VECS[v].exp_irq, int'(VECS[v].req), $sformatf("vector %0d irq", v));
        end

        // R10: irq stays high across many idle clocks and reads
        bus_write(16'h5000, 8'hFE);
        bus_write(16'h5800, 8'hFF);
        idle(1);
        check1(irq, 1'b1, 5, "irq at terminal before reset test");
        idle(20);
        peek(16'h5000);
        check1(irq, 1'b1, 10, "irq held with reads only");

        // R1: reset mid-interrupt clears everything and counting stays off
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check1(irq, 1'b0, 1, "irq after second reset");
        peek(16'h5800);
        check8(bus_rdata, 8'h00, 1, "high byte after second reset");
        idle(3);
        peek(16'h5000);
        check8(bus_rdata, 8'h00, 1, "low byte stays zero after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule